// File: doc/BRIEF.md
# Banked Index Address Register File

This block keeps the index registers that a small 8-bit core uses to reach its data memory, and turns them into a 16-bit data address. Two banks exist, and each carries a page register and two offset registers, all 8 bits wide. Bit 2 of the core's status register picks the active bank. That bank receives every write, serves every read and feeds the address output.

The address joins the active page register (upper byte) with one offset register (lower byte). An offset-select input picks the offset register, so the address space is 64K bytes. The core can keep one page/offset pair as a software stack pointer and switch banks to reach a second, untouched set.

Bank tracking is a two-state machine with states `BANK_LO` (bank 0) and `BANK_HI` (bank 1). Transition `LO_TO_HI` fires at a clock edge when status bit 2 is 1 in `BANK_LO`. Transition `HI_TO_LO` fires when that bit is 0 in `BANK_HI`. Otherwise the state holds. Reset forces `BANK_LO`.

Top module: `idx_regfile`

## Requirements
- R1: A synchronous reset clears all six registers to zero and enters `BANK_LO`. The read port and the address output then show zero.
- R2: A write with `wr_en_i`=1 loads `wr_data_i` at the clock edge into the active-bank register named by `wr_sel_i`, where 0 is page, 1 is offset 0 and 2 is offset 1. The new value appears on the read port right after that edge.
- R3: A write with `wr_sel_i`=3 changes no register.
- R4: Registers of the inactive bank keep their contents across writes to the other bank and across any number of bank switches.
- R5: The active bank follows bit 2 of `status_i` as sampled at each clock edge, with 0 meaning bank 0 and 1 meaning bank 1. A change first takes effect on reads, writes and the address in the cycle after the edge.
- R6: `addr_o[15:8]` is the active page register. `addr_o[7:0]` is offset 0 when `off_sel_i`=0 and offset 1 when `off_sel_i`=1.
- R7: `rd_sel_i` uses the same codes as `wr_sel_i`. Code 3 reads as zero.
- R8: Status bits other than bit 2 have no effect on bank choice.
- R9: With `wr_en_i`=0, no register changes, whatever `wr_sel_i` and `wr_data_i` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| status_i | input | 8 | Core status register; bit 2 selects the bank |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 page, 1 offset 0, 2 offset 1, 3 none |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Read target, same codes; 3 reads zero |
| rd_data_o | output | 8 | Read data from the active bank |
| off_sel_i | input | 1 | Offset register used for the address |
| addr_o | output | 16 | Page:offset data address |

## Verification
A bank state that disagrees with the status bit shows up at once on the read port and in the address. Values written earlier to the other bank appear, or fresh writes vanish after a switch back. A corrupted or wrongly enabled register shows up as a wrong byte on the read port in the same cycle it is selected. A write that lands in both banks, or in the wrong bank, only shows up after a later bank switch, so the bench always writes distinct values per bank and reads both banks back after switching.

// File: rtl/idx_pkg.sv
package idx_pkg;
    typedef enum logic [0:0] {
        BANK_LO = 1'b0,
        BANK_HI = 1'b1
    } bank_e;

    typedef enum logic [1:0] {
        SEL_PAGE = 2'd0,
        SEL_OFF0 = 2'd1,
        SEL_OFF1 = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/idx_bank_fsm.sv
module idx_bank_fsm
    import idx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bank_bit_i,
    output bank_e bank_o
);
    bank_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= BANK_LO;
        else     state_q <= state_d;
    end

    // transitions LO_TO_HI / HI_TO_LO
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK_LO: if (bank_bit_i)  state_d = BANK_HI;
            BANK_HI: if (!bank_bit_i) state_d = BANK_LO;
            default: state_d = BANK_LO;
        endcase
    end

    // output process
    always_comb bank_o = state_q;
endmodule

// File: rtl/idx_bank.sv
module idx_bank
    import idx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  reg_sel_e      sel_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] page_o,
    output logic [DW-1:0] off0_o,
    output logic [DW-1:0] off1_o
);
    logic [DW-1:0] page_q, off0_q, off1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            off0_q <= '0;
            off1_q <= '0;
        end else if (we_i) begin
            unique case (sel_i)
                SEL_PAGE: page_q <= data_i;
                SEL_OFF0: off0_q <= data_i;
                SEL_OFF1: off1_q <= data_i;
                SEL_NONE: ;
                default:  ;
            endcase
        end
    end

    assign page_o = page_q;
    assign off0_o = off0_q;
    assign off1_o = off1_q;

    // R4 / R9: a bank not enabled holds all its registers
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> ($stable(page_o) && $stable(off0_o) && $stable(off1_o)));

    // R3: the unused write code touches nothing
    assert_none_code_R3: assert property (@(posedge clk) disable iff (rst)
        (we_i && sel_i == SEL_NONE) |=> ($stable(page_o) && $stable(off0_o) && $stable(off1_o)));
endmodule

// File: rtl/idx_regfile.sv
module idx_regfile
    import idx_pkg::*;
#(
    parameter int DW       = 8,
    parameter int STAT_W   = 8,
    parameter int BANK_BIT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [STAT_W-1:0] status_i,
    input  logic            wr_en_i,
    input  logic [1:0]      wr_sel_i,
    input  logic [DW-1:0]   wr_data_i,
    input  logic [1:0]      rd_sel_i,
    output logic [DW-1:0]   rd_data_o,
    input  logic            off_sel_i,
    output logic [2*DW-1:0] addr_o
);
    localparam int NB = 2;

    bank_e         bank;
    logic [NB-1:0] bank_we;
    logic [DW-1:0] page_w [NB];
    logic [DW-1:0] off0_w [NB];
    logic [DW-1:0] off1_w [NB];
    logic [DW-1:0] act_page, act_off0, act_off1;

    idx_bank_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .bank_bit_i (status_i[BANK_BIT]),
        .bank_o     (bank)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign bank_we[b] = wr_en_i && (int'(bank) == b);
        idx_bank #(.DW(DW)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .we_i   (bank_we[b]),
            .sel_i  (reg_sel_e'(wr_sel_i)),
            .data_i (wr_data_i),
            .page_o (page_w[b]),
            .off0_o (off0_w[b]),
            .off1_o (off1_w[b])
        );
    end

    assign act_page = page_w[bank];
    assign act_off0 = off0_w[bank];
    assign act_off1 = off1_w[bank];

    always_comb begin
        unique case (reg_sel_e'(rd_sel_i))
            SEL_PAGE: rd_data_o = act_page;
            SEL_OFF0: rd_data_o = act_off0;
            SEL_OFF1: rd_data_o = act_off1;
            default:  rd_data_o = '0;
        endcase
    end

    assign addr_o = {act_page, off_sel_i ? act_off1 : act_off0};

    // R2/R4: at most one bank takes a write
    assert_single_bank_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_we));

    // R1: outputs are zero right after reset
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (addr_o == '0 && rd_data_o == '0));

    // R6: a page write with an unchanged bank shows in the upper address byte
    assert_page_addr_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sel_i == SEL_PAGE && status_i[BANK_BIT] == bank)
        |=> addr_o[2*DW-1:DW] == $past(wr_data_i));

    // R6: an offset 1 write appears in the lower byte when offset 1 is chosen
    assert_off1_addr_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sel_i == SEL_OFF1 && status_i[BANK_BIT] == bank)
        |=> (!off_sel_i || addr_o[DW-1:0] == $past(wr_data_i)));
endmodule

// File: tb/idx_regfile_tb.sv
module idx_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  status_i = 8'h00;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = 2'd0;
    logic [7:0]  wr_data_i = 8'h00;
    logic [1:0]  rd_sel_i = 2'd0;
    logic [7:0]  rd_data_o;
    logic        off_sel_i = 1'b0;
    logic [15:0] addr_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    idx_regfile dut_i (
        .clk(clk), .rst(rst), .status_i(status_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
        .rd_data_o(rd_data_o), .off_sel_i(off_sel_i), .addr_o(addr_o)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] d);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic bank_to(logic b);
        status_i[2] = b;
        tick();
    endtask

    task automatic rd_chk(string req, logic [1:0] sel, logic [7:0] exp);
        rd_sel_i = sel;
        #1;
        chk(req, {8'h00, rd_data_o}, {8'h00, exp});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        #1;
        rd_chk("R1 page", 2'd0, 8'h00);
        rd_chk("R1 off0", 2'd1, 8'h00);
        rd_chk("R1 off1", 2'd2, 8'h00);
        chk("R1 addr", addr_o, 16'h0000);
    endtask

    task automatic t_write_read();
        wr(2'd0, 8'h12);
        rd_chk("R2 page", 2'd0, 8'h12);
        wr(2'd1, 8'h34);
        wr(2'd2, 8'h56);
        rd_chk("R2 off0", 2'd1, 8'h34);
        rd_chk("R2 off1", 2'd2, 8'h56);
        rd_chk("R7 code3", 2'd3, 8'h00);
    endtask

    task automatic t_addr();
        off_sel_i = 1'b0; #1;
        chk("R6 addr off0", addr_o, 16'h1234);
        off_sel_i = 1'b1; #1;
        chk("R6 addr off1", addr_o, 16'h1256);
        off_sel_i = 1'b0;
    endtask

    task automatic t_ignored();
        wr(2'd3, 8'hEE);
        rd_chk("R3 page", 2'd0, 8'h12);
        rd_chk("R3 off0", 2'd1, 8'h34);
        rd_chk("R3 off1", 2'd2, 8'h56);
        wr_en_i = 1'b0; wr_sel_i = 2'd0; wr_data_i = 8'hDD;
        tick();
        rd_chk("R9 no enable", 2'd0, 8'h12);
    endtask

    task automatic t_banks();
        // timing: status changes, same-cycle read still old bank
        status_i[2] = 1'b1;
        rd_chk("R5 before edge", 2'd0, 8'h12);
        tick();
        rd_chk("R5 after edge", 2'd0, 8'h00);
        wr(2'd0, 8'hA1);
        wr(2'd1, 8'hB2);
        wr(2'd2, 8'hC3);
        chk("R6 bank1 addr", addr_o, 16'hA1B2);
        bank_to(1'b0);
        rd_chk("R4 bank0 page", 2'd0, 8'h12);
        rd_chk("R4 bank0 off1", 2'd2, 8'h56);
        bank_to(1'b1);
        rd_chk("R4 bank1 page", 2'd0, 8'hA1);
        rd_chk("R4 bank1 off0", 2'd1, 8'hB2);
        rd_chk("R4 bank1 off1", 2'd2, 8'hC3);
        // other status bits ignored
        status_i = 8'hFB;
        tick();
        rd_chk("R8 bank0 via 0xFB", 2'd0, 8'h12);
        status_i = 8'h04;
        tick();
        rd_chk("R8 bank1 via 0x04", 2'd1, 8'hB2);
        status_i = 8'h00;
        tick();
    endtask

    task automatic t_reset_both();
        t_reset();
        bank_to(1'b1);
        rd_chk("R1 bank1 page", 2'd0, 8'h00);
        rd_chk("R1 bank1 off1", 2'd2, 8'h00);
        bank_to(1'b0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #2;
        t_reset();
        t_write_read();
        t_addr();
        t_ignored();
        t_banks();
        t_reset_both();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule